// File: doc/BRIEF.md
# HDLC receive address filter

The filter sits between an HDLC receive deframer and a receive FIFO. It takes a byte stream marked with start and end of frame, where the deframer supplies the CRC verdict and an abort indication with the final octet. It compares the leading address octets of each frame against two fixed group addresses and four programmable compare values, each under a per-bit mask. A frame that is accepted is forwarded toward the FIFO with its address octets removed, as the mode dictates. One status octet is appended to it and carries the out-of-band frame information. A frame that is refused leaves no trace in the FIFO.

Three recognition modes are selected per frame. The mode is sampled with the start-of-frame octet.
- **Transparent:** all octets are forwarded.
- **High-octet:** only the first (high) address octet is compared and stripped.
- **Full:** one or two address octets are compared and stripped. With a single address octet the two low compare values also classify the frame as command or response.

The output is a valid/ready byte stream. The input is stalled whenever the output cannot move.

The controller is a five-state machine:
- **IDLE:** waits for a start-of-frame octet. Stray octets are dropped here. From IDLE the machine goes to PASS in transparent mode and to ADDR otherwise.
- **ADDR:** consumes the address octets. On the last address octet it goes to one of three states:
  - PASS on a match;
  - DROP on a mismatch;
  - STATUS when a matching frame ends on its last address octet.

  It returns to IDLE on a mismatch at end of frame, or when the frame ends early.
- **PASS:** forwards octets until end of frame, then goes to STATUS.
- **STATUS:** emits the status octet and returns to IDLE when it is taken.
- **DROP:** discards octets up to end of frame and returns to IDLE.

Top module: `hdlc_addr_filter`

## Requirements
- R1: Mode code 0 (and the reserved code 3) forwards every octet of a frame unchanged, followed by a status octet whose match-source field is 3.
- R2: Mode code 1 compares the first octet with group values FE/FC hex and with high compare values 1 and 2. On a match it forwards the frame from the second octet onward.
- R3: Mode code 2 with a single address octet compares the first octet with low compare values 1 and 2. It forwards from the second octet. Status bit 2 is 1 for a match on low compare 2 (response) and 0 for a match on low compare 1 (command).
- R4: Mode code 2 with two address octets accepts a frame only when the first octet matches a group or high compare value and the second octet matches a low compare value. It forwards from the third octet.
- R5: A mask bit of 1 makes that address bit a don't-care in every comparison, the group values included. The high mask applies to high octets and the low mask to low octets.
- R6: A frame whose address does not match produces no output octet at all.
- R7: A frame that ends before all its address octets have arrived produces no output. A matching frame that ends on its last address octet produces only the status octet.
- R8: The status octet is the last octet of each stored frame and the only one with out_last set. Its fields are:
  - bit 7: CRC ok and no abort;
  - bit 6: CRC ok;
  - bit 5: abort;
  - bits 4:3: match source;
  - bit 2: response;
  - bits 1:0: zero.

  A non-status octet never carries out_last.
- R9: While out_valid is high and out_ready low, out_data and out_last hold and in_ready is low.
- R10: Octets that arrive outside a frame (no start-of-frame marker while idle) are consumed and ignored.
- R11: Match source is encoded as 0 for group, 1 for compare 1, 2 for compare 2, with priority in that order. In two-octet full mode the source comes from the high octet.
- R12: Out of reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Recognition mode: 0 transparent, 1 high octet, 2 full, 3 treated as 0 |
| cfg_two_octet | input | 1 | Full mode uses a two-octet address |
| cfg_hi_cmp1 | input | 8 | High-octet compare value 1 |
| cfg_hi_cmp2 | input | 8 | High-octet compare value 2 |
| cfg_lo_cmp1 | input | 8 | Low-octet compare value 1 (command) |
| cfg_lo_cmp2 | input | 8 | Low-octet compare value 2 (response) |
| cfg_hi_mask | input | 8 | Don't-care bits for high-octet comparisons |
| cfg_lo_mask | input | 8 | Don't-care bits for low-octet comparisons |
| in_valid | input | 1 | Input octet present |
| in_data | input | 8 | Input octet |
| in_sof | input | 1 | Octet is the first of a frame |
| in_eof | input | 1 | Octet is the last of a frame |
| in_crc_ok | input | 1 | CRC verdict, meaningful with in_eof |
| in_abort | input | 1 | Frame aborted, meaningful with in_eof |
| in_ready | output | 1 | Filter accepts the input octet |
| out_valid | output | 1 | Output octet present |
| out_data | output | 8 | Output octet |
| out_last | output | 1 | Output octet is the status octet ending a frame |
| out_ready | input | 1 | FIFO accepts the output octet |

## Verification
The bench builds the filter with its default group values FE and FC hex, so that its own model of the fixed group comparison uses the same pair. Because the compare values and masks are ports, every mode, every match source and the masked comparisons are all reachable with that single build. Frames of one and two octets bring within reach the boundaries where a frame ends on or before its last address octet. A random out_ready pattern exercises the stall behaviour of both the forwarded octets and the status octet.

// File: rtl/hdlc_af_pkg.sv
`timescale 1ns/1ps
package hdlc_af_pkg;
    localparam int OCTET_W = 8;

    typedef enum logic [1:0] {
        AM_NONE = 2'd0,
        AM_HIGH = 2'd1,
        AM_FULL = 2'd2,
        AM_RSVD = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        SRC_GROUP = 2'd0,
        SRC_CMP1  = 2'd1,
        SRC_CMP2  = 2'd2,
        SRC_NONE  = 2'd3
    } match_src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PASS,
        ST_STATUS,
        ST_DROP
    } af_state_e;

    typedef struct packed {
        logic       good;
        logic       crc_ok;
        logic       abort;
        match_src_e src;
        logic       resp;
        logic [1:0] spare;
    } status_t;

    function automatic logic octet_eq(input logic [OCTET_W-1:0] a,
                                      input logic [OCTET_W-1:0] b,
                                      input logic [OCTET_W-1:0] dc);
        return ((a ^ b) & ~dc) == '0;
    endfunction
endpackage

// File: rtl/hdlc_af_match.sv
`timescale 1ns/1ps
module hdlc_af_match
    import hdlc_af_pkg::*;
#(
    parameter bit                 USE_GROUP = 1'b1,
    parameter logic [OCTET_W-1:0] GRP_A     = 8'hFE,
    parameter logic [OCTET_W-1:0] GRP_B     = 8'hFC
) (
    input  logic [OCTET_W-1:0] octet,
    input  logic [OCTET_W-1:0] mask,
    input  logic [OCTET_W-1:0] cmp1,
    input  logic [OCTET_W-1:0] cmp2,
    output logic               hit,
    output match_src_e         src
);
    logic grp_hit;
    logic c1_hit;
    logic c2_hit;

    generate
        if (USE_GROUP) begin : g_grp
            assign grp_hit = octet_eq(octet, GRP_A, mask) | octet_eq(octet, GRP_B, mask);
        end else begin : g_nogrp
            assign grp_hit = 1'b0;
        end
    endgenerate

    assign c1_hit = octet_eq(octet, cmp1, mask);
    assign c2_hit = octet_eq(octet, cmp2, mask);
    assign hit    = grp_hit | c1_hit | c2_hit;

    // fixed priority: group, then compare 1, then compare 2
    always_comb begin
        if (grp_hit)     src = SRC_GROUP;
        else if (c1_hit) src = SRC_CMP1;
        else if (c2_hit) src = SRC_CMP2;
        else             src = SRC_NONE;
    end
endmodule

// File: rtl/hdlc_af_status.sv
`timescale 1ns/1ps
module hdlc_af_status
    import hdlc_af_pkg::*;
(
    input  logic               crc_ok,
    input  logic               abort,
    input  match_src_e         src,
    input  logic               resp,
    output logic [OCTET_W-1:0] status_octet
);
    status_t st;

    always_comb begin
        st.good   = crc_ok & ~abort;
        st.crc_ok = crc_ok;
        st.abort  = abort;
        st.src    = src;
        st.resp   = resp;
        st.spare  = 2'b00;
    end

    assign status_octet = st;
endmodule

// File: rtl/hdlc_af_ctrl.sv
`timescale 1ns/1ps
module hdlc_af_ctrl
    import hdlc_af_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  addr_mode_e cfg_mode,
    input  logic       cfg_two_octet,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       in_crc_ok,
    input  logic       in_abort,
    input  logic       out_ready,
    input  logic       hi_hit,
    input  match_src_e hi_src,
    input  logic       lo_hit,
    input  match_src_e lo_src,
    output logic       in_ready,
    output logic       out_valid,
    output logic       out_last,
    output logic       sel_status,
    output logic       st_crc_ok,
    output logic       st_abort,
    output match_src_e st_src,
    output logic       st_resp
);
    af_state_e  state_q, state_d;
    addr_mode_e mode_q, mode_d;
    logic       two_q, two_d;
    logic       idx_q, idx_d;
    logic       hi_ok_q, hi_ok_d;
    match_src_e hi_src_q, hi_src_d;
    match_src_e src_q, src_d;
    logic       resp_q, resp_d;
    logic       crc_q, crc_d;
    logic       abort_q, abort_d;

    logic       addr_last;
    logic       addr_ok;
    match_src_e addr_src;
    logic       addr_resp;
    addr_mode_e mode_eff;

    assign mode_eff = (cfg_mode == AM_RSVD) ? AM_NONE : cfg_mode;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= AM_NONE;
            two_q    <= 1'b0;
            idx_q    <= 1'b0;
            hi_ok_q  <= 1'b0;
            hi_src_q <= SRC_NONE;
            src_q    <= SRC_NONE;
            resp_q   <= 1'b0;
            crc_q    <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            mode_q   <= mode_d;
            two_q    <= two_d;
            idx_q    <= idx_d;
            hi_ok_q  <= hi_ok_d;
            hi_src_q <= hi_src_d;
            src_q    <= src_d;
            resp_q   <= resp_d;
            crc_q    <= crc_d;
            abort_q  <= abort_d;
        end
    end

    // verdict on the address octet currently presented
    always_comb begin
        addr_last = !(mode_q == AM_FULL && two_q && !idx_q);
        addr_ok   = 1'b0;
        addr_src  = SRC_NONE;
        addr_resp = 1'b0;
        unique case (mode_q)
            AM_HIGH: begin
                addr_ok  = hi_hit;
                addr_src = hi_src;
            end
            AM_FULL: begin
                if (two_q) begin
                    addr_ok  = hi_ok_q && lo_hit;
                    addr_src = hi_src_q;
                end else begin
                    addr_ok  = lo_hit;
                    addr_src = lo_src;
                end
                addr_resp = (lo_src == SRC_CMP2);
            end
            default: ;
        endcase
    end

    // next state
    always_comb begin
        state_d  = state_q;
        mode_d   = mode_q;
        two_d    = two_q;
        idx_d    = idx_q;
        hi_ok_d  = hi_ok_q;
        hi_src_d = hi_src_q;
        src_d    = src_q;
        resp_d   = resp_q;
        crc_d    = crc_q;
        abort_d  = abort_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_sof) begin
                    mode_d   = mode_eff;
                    two_d    = cfg_two_octet;
                    idx_d    = 1'b0;
                    hi_ok_d  = 1'b0;
                    hi_src_d = SRC_NONE;
                    src_d    = SRC_NONE;
                    resp_d   = 1'b0;
                    state_d  = (mode_eff == AM_NONE) ? ST_PASS : ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (in_valid) begin
                    if (addr_last) begin
                        if (addr_ok) begin
                            src_d  = addr_src;
                            resp_d = addr_resp;
                        end
                        if (in_eof) begin
                            crc_d   = in_crc_ok;
                            abort_d = in_abort;
                            state_d = addr_ok ? ST_STATUS : ST_IDLE;
                        end else begin
                            state_d = addr_ok ? ST_PASS : ST_DROP;
                        end
                    end else begin
                        idx_d    = 1'b1;
                        hi_ok_d  = hi_hit;
                        hi_src_d = hi_src;
                        if (in_eof) state_d = ST_IDLE;
                    end
                end
            end
            ST_PASS: begin
                if (in_valid && out_ready && in_eof) begin
                    crc_d   = in_crc_ok;
                    abort_d = in_abort;
                    state_d = ST_STATUS;
                end
            end
            ST_STATUS: begin
                if (out_ready) state_d = ST_IDLE;
            end
            ST_DROP: begin
                if (in_valid && in_eof) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        out_last   = 1'b0;
        sel_status = 1'b0;
        unique case (state_q)
            ST_IDLE:          in_ready = !(in_valid && in_sof);
            ST_ADDR, ST_DROP: in_ready = 1'b1;
            ST_PASS: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
            ST_STATUS: begin
                out_valid  = 1'b1;
                out_last   = 1'b1;
                sel_status = 1'b1;
            end
            default: ;
        endcase
    end

    assign st_crc_ok = crc_q;
    assign st_abort  = abort_q;
    assign st_src    = src_q;
    assign st_resp   = resp_q;
endmodule

// File: rtl/hdlc_addr_filter.sv
`timescale 1ns/1ps
module hdlc_addr_filter
    import hdlc_af_pkg::*;
#(
    parameter logic [OCTET_W-1:0] GRP_ADDR_A = 8'hFE,
    parameter logic [OCTET_W-1:0] GRP_ADDR_B = 8'hFC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_two_octet,
    input  logic [OCTET_W-1:0] cfg_hi_cmp1,
    input  logic [OCTET_W-1:0] cfg_hi_cmp2,
    input  logic [OCTET_W-1:0] cfg_lo_cmp1,
    input  logic [OCTET_W-1:0] cfg_lo_cmp2,
    input  logic [OCTET_W-1:0] cfg_hi_mask,
    input  logic [OCTET_W-1:0] cfg_lo_mask,
    input  logic               in_valid,
    input  logic [OCTET_W-1:0] in_data,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic               in_crc_ok,
    input  logic               in_abort,
    output logic               in_ready,
    output logic               out_valid,
    output logic [OCTET_W-1:0] out_data,
    output logic               out_last,
    input  logic               out_ready
);
    logic               hi_hit, lo_hit;
    match_src_e         hi_src, lo_src;
    logic               sel_status;
    logic               st_crc_ok, st_abort, st_resp;
    match_src_e         st_src;
    logic [OCTET_W-1:0] status_octet;

    hdlc_af_match #(
        .USE_GROUP (1'b1),
        .GRP_A     (GRP_ADDR_A),
        .GRP_B     (GRP_ADDR_B)
    ) u_hi_match (
        .octet (in_data),
        .mask  (cfg_hi_mask),
        .cmp1  (cfg_hi_cmp1),
        .cmp2  (cfg_hi_cmp2),
        .hit   (hi_hit),
        .src   (hi_src)
    );

    hdlc_af_match #(
        .USE_GROUP (1'b0),
        .GRP_A     (GRP_ADDR_A),
        .GRP_B     (GRP_ADDR_B)
    ) u_lo_match (
        .octet (in_data),
        .mask  (cfg_lo_mask),
        .cmp1  (cfg_lo_cmp1),
        .cmp2  (cfg_lo_cmp2),
        .hit   (lo_hit),
        .src   (lo_src)
    );

    hdlc_af_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_mode      (addr_mode_e'(cfg_mode)),
        .cfg_two_octet (cfg_two_octet),
        .in_valid      (in_valid),
        .in_sof        (in_sof),
        .in_eof        (in_eof),
        .in_crc_ok     (in_crc_ok),
        .in_abort      (in_abort),
        .out_ready     (out_ready),
        .hi_hit        (hi_hit),
        .hi_src        (hi_src),
        .lo_hit        (lo_hit),
        .lo_src        (lo_src),
        .in_ready      (in_ready),
        .out_valid     (out_valid),
        .out_last      (out_last),
        .sel_status    (sel_status),
        .st_crc_ok     (st_crc_ok),
        .st_abort      (st_abort),
        .st_src        (st_src),
        .st_resp       (st_resp)
    );

    hdlc_af_status u_status (
        .crc_ok       (st_crc_ok),
        .abort        (st_abort),
        .src          (st_src),
        .resp         (st_resp),
        .status_octet (status_octet)
    );

    assign out_data = sel_status ? status_octet : in_data;
endmodule

// File: rtl/hdlc_af_chk.sv
`timescale 1ns/1ps
module hdlc_af_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       out_ready
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R9
    in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R8
    status_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (out_data[1:0] == 2'b00));

    // R8
    frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && out_ready) |=> !out_valid);

    // R12
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!out_valid);
        end
    end
endmodule

bind hdlc_addr_filter hdlc_af_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/hdlc_addr_filter_test.sv
`timescale 1ns/1ps
module hdlc_addr_filter_test;
    typedef logic [7:0] oct_q [$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_two_octet = 1'b0;
    logic [7:0] cfg_hi_cmp1 = 8'h00, cfg_hi_cmp2 = 8'h00;
    logic [7:0] cfg_lo_cmp1 = 8'h00, cfg_lo_cmp2 = 8'h00;
    logic [7:0] cfg_hi_mask = 8'h00, cfg_lo_mask = 8'h00;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic       in_crc_ok = 1'b0, in_abort = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, out_last;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;

    int         checks = 0;
    int         fails = 0;
    string      cur_req = "R1";
    logic [8:0] exp_q [$];
    bit         bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit         done = 1'b0;

    hdlc_addr_filter uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_mode (cfg_mode), .cfg_two_octet (cfg_two_octet),
        .cfg_hi_cmp1 (cfg_hi_cmp1), .cfg_hi_cmp2 (cfg_hi_cmp2),
        .cfg_lo_cmp1 (cfg_lo_cmp1), .cfg_lo_cmp2 (cfg_lo_cmp2),
        .cfg_hi_mask (cfg_hi_mask), .cfg_lo_mask (cfg_lo_mask),
        .in_valid (in_valid), .in_data (in_data), .in_sof (in_sof), .in_eof (in_eof),
        .in_crc_ok (in_crc_ok), .in_abort (in_abort), .in_ready (in_ready),
        .out_valid (out_valid), .out_data (out_data), .out_last (out_last),
        .out_ready (out_ready)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= bp_en ? lfsr[3] : 1'b1;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            summary();
            $finish;
        end
    end

    // behavioural model of the requirements
    function automatic bit meq(logic [7:0] a, logic [7:0] b, logic [7:0] m);
        for (int i = 0; i < 8; i++)
            if (!m[i] && a[i] != b[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [1:0] class_hi(logic [7:0] d);
        if (meq(d, 8'hFE, cfg_hi_mask) || meq(d, 8'hFC, cfg_hi_mask)) return 2'd0;
        if (meq(d, cfg_hi_cmp1, cfg_hi_mask)) return 2'd1;
        if (meq(d, cfg_hi_cmp2, cfg_hi_mask)) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [1:0] class_lo(logic [7:0] d);
        if (meq(d, cfg_lo_cmp1, cfg_lo_mask)) return 2'd1;
        if (meq(d, cfg_lo_cmp2, cfg_lo_mask)) return 2'd2;
        return 2'd3;
    endfunction

    task automatic model(oct_q d, bit crc, bit ab);
        int eff, need;
        bit ok, resp;
        logic [1:0] src, h, l;
        eff  = (cfg_mode == 2'd3) ? 0 : int'(cfg_mode);
        need = (eff == 0) ? 0 : (eff == 1) ? 1 : (cfg_two_octet ? 2 : 1);
        if (d.size() < need) return;
        ok = 1'b1; src = 2'd3; resp = 1'b0;
        if (eff == 1) begin
            h = class_hi(d[0]); ok = (h != 2'd3); src = h;
        end else if (eff == 2) begin
            if (cfg_two_octet) begin
                h = class_hi(d[0]); l = class_lo(d[1]);
                ok = (h != 2'd3) && (l != 2'd3); src = h; resp = (l == 2'd2);
            end else begin
                l = class_lo(d[0]); ok = (l != 2'd3); src = l; resp = (l == 2'd2);
            end
        end
        if (!ok) return;
        for (int i = need; i < d.size(); i++) exp_q.push_back({1'b0, d[i]});
        exp_q.push_back({1'b1, crc && !ab, crc, ab, src, resp, 2'b00});
    endtask

    task automatic put_octet(logic [7:0] b, bit sof, bit eof, bit crc, bit ab);
        bit rdy;
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_sof = sof; in_eof = eof;
        in_crc_ok = crc; in_abort = ab;
        forever begin
            #9;
            rdy = in_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
    endtask

    task automatic run(oct_q d, bit crc, bit ab);
        model(d, crc, ab);
        for (int i = 0; i < d.size(); i++)
            put_octet(d[i], i == 0, i == d.size() - 1, crc, ab);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // output monitor, compared against the model every clock
    initial begin
        bit stall_prev = 1'b0;
        logic [7:0] prev_data = 8'h00;
        logic prev_last = 1'b0;
        logic [8:0] e;
        forever begin
            @(negedge clk);
            #8;
            if (rst_n) begin
                if (stall_prev) begin
                    checks++;
                    if (!(out_valid && out_data == prev_data && out_last == prev_last)) begin
                        fails++;
                        $display("FAIL R9 hold: actual v=%0b d=%h l=%0b expected v=1 d=%h l=%0b",
                                 out_valid, out_data, out_last, prev_data, prev_last);
                    end
                end
                if (out_valid && !out_ready) begin
                    checks++;
                    if (in_ready) begin
                        fails++;
                        $display("FAIL R9 in_ready during stall: actual 1 expected 0");
                    end
                end
                stall_prev = out_valid && !out_ready;
                prev_data  = out_data;
                prev_last  = out_last;
                if (out_valid && out_ready) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL %s unexpected octet: actual %h last=%0b expected none",
                                 cur_req, out_data, out_last);
                    end else begin
                        e = exp_q.pop_front();
                        if ({out_last, out_data} !== e) begin
                            fails++;
                            $display("FAIL %s octet: actual last=%0b %h expected last=%0b %h",
                                     cur_req, out_last, out_data, e[8], e[7:0]);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R12 reset: actual v=%b r=%b expected v=0 r=1", out_valid, in_ready);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: transparent mode and reserved code
        cur_req = "R1"; cfg_mode = 2'd0;
        run('{8'h11, 8'h22, 8'h33}, 1'b1, 1'b0);
        run('{8'h5A}, 1'b1, 1'b0);
        cfg_mode = 2'd3;
        run('{8'h01, 8'h02}, 1'b1, 1'b0);

        // R2: high-octet mode
        cur_req = "R2"; cfg_mode = 2'd1;
        cfg_hi_cmp1 = 8'h40; cfg_hi_cmp2 = 8'h42;
        run('{8'hFE, 8'h05, 8'hAA, 8'hBB}, 1'b1, 1'b0);
        run('{8'hFC, 8'h07, 8'hCC}, 1'b1, 1'b0);
        run('{8'h40, 8'h01, 8'h77}, 1'b1, 1'b0);
        run('{8'h42, 8'h09}, 1'b1, 1'b0);

        // R6: mismatches leave no output
        cur_req = "R6";
        run('{8'h41, 8'h01, 8'h77}, 1'b1, 1'b0);

        // R3: single-octet full mode, command and response
        cur_req = "R3"; cfg_mode = 2'd2; cfg_two_octet = 1'b0;
        cfg_lo_cmp1 = 8'h01; cfg_lo_cmp2 = 8'h03;
        run('{8'h01, 8'hC0, 8'h55}, 1'b1, 1'b0);
        run('{8'h03, 8'hC1}, 1'b1, 1'b0);
        cur_req = "R6";
        run('{8'h07, 8'hC1, 8'h99}, 1'b1, 1'b0);

        // R4: two-octet full mode
        cur_req = "R4"; cfg_two_octet = 1'b1;
        cfg_lo_cmp1 = 8'h10; cfg_lo_cmp2 = 8'h20;
        run('{8'h40, 8'h20, 8'hAA, 8'hBB}, 1'b1, 1'b0);
        run('{8'hFE, 8'h10, 8'hCC}, 1'b1, 1'b0);
        cur_req = "R6";
        run('{8'h40, 8'h33, 8'hDD}, 1'b1, 1'b0);
        run('{8'h41, 8'h10, 8'hDD}, 1'b1, 1'b0);

        // R7: short frames and frames ending on the address
        cur_req = "R7";
        run('{8'h40}, 1'b1, 1'b0);
        run('{8'h40, 8'h10}, 1'b1, 1'b0);
        cfg_two_octet = 1'b0; cfg_lo_cmp1 = 8'h01;
        run('{8'h01}, 1'b1, 1'b0);
        cfg_mode = 2'd1;
        run('{8'hFE}, 1'b1, 1'b0);

        // R5: masks, group values included
        cur_req = "R5"; cfg_hi_mask = 8'h01;
        run('{8'hFF, 8'h12, 8'h34}, 1'b1, 1'b0);
        run('{8'h41, 8'h12}, 1'b1, 1'b0);
        cfg_hi_mask = 8'h00;
        cfg_mode = 2'd2; cfg_two_octet = 1'b0; cfg_lo_mask = 8'h0F; cfg_lo_cmp1 = 8'h10;
        run('{8'h1A, 8'h66}, 1'b1, 1'b0);
        run('{8'h2A, 8'h66}, 1'b1, 1'b0);
        cfg_lo_mask = 8'h00;

        // R11: source priority
        cur_req = "R11"; cfg_mode = 2'd1;
        cfg_hi_cmp1 = 8'hFE;
        run('{8'hFE, 8'h01}, 1'b1, 1'b0);
        cfg_hi_cmp1 = 8'h40; cfg_hi_cmp2 = 8'h40;
        run('{8'h40, 8'h01}, 1'b1, 1'b0);
        cfg_hi_cmp2 = 8'h42;

        // R8: status fields for bad CRC and abort
        cur_req = "R8"; cfg_mode = 2'd0;
        run('{8'h21, 8'h22}, 1'b0, 1'b0);
        run('{8'h31, 8'h32}, 1'b1, 1'b1);

        // R10: stray octets outside a frame
        cur_req = "R10";
        put_octet(8'h99, 1'b0, 1'b0, 1'b0, 1'b0);
        put_octet(8'h98, 1'b0, 1'b1, 1'b1, 1'b0);
        @(negedge clk); in_valid = 1'b0; in_eof = 1'b0;
        run('{8'h44, 8'h45}, 1'b1, 1'b0);

        // R9: backpressure across modes
        cur_req = "R9"; bp_en = 1'b1;
        for (int f = 0; f < 6; f++) begin
            cfg_mode = 2'(f % 3);
            cfg_two_octet = f[1];
            run('{8'hFE, 8'h10, 8'(f), 8'hA0, 8'hA1, 8'hA2}, 1'b1, 1'b0);
        end
        bp_en = 1'b0;
        repeat (4) @(negedge clk);

        // R6: nothing left outstanding
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R6 pending: actual %0d octets expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule